// File: doc/BRIEF.md
# Least-Squares Timestamp Sum Accumulator

This block is the hardware front end of a regression-based frequency counter. A time-to-digital stage produces one pair per input edge: the running edge count (the abscissa) and the captured timestamp (the ordinate). The block folds every accepted pair into five running sums over a measurement gate: the sample count N, Σx, Σy, Σxy and Σx². A downstream divider or processor uses these sums to solve for the least-squares slope. The slope is the period, and its reciprocal is the frequency. Fitting a line through every edge gives a resolution finer than the raw timestamp step, and the gain grows with the number of samples.

Both coordinates are taken relative to the first sample of the gate, so the squared and cross sums stay bounded. Sampling runs at up to one pair per clock through a valid/ready handshake. A three-stage pipeline computes the offsets, then the products, then the sums. A gate-start pulse opens a gate and clears all state. A gate-stop pulse waits for the pipeline to empty, then latches the sums and raises a one-cycle result strobe. Each result also carries a validity flag and a sticky overflow flag.

Top module: `lsq_gate_accum`

## Requirements
- R1: After reset, `result_valid`, `in_ready`, `res_ok`, `res_ovf` and all result sums are 0.
- R2: `in_ready` is 1 only while a gate is open and `gate_start` is low. It is 0 when idle and while draining after `gate_stop`. Pairs offered while it is 0 contribute nothing to any result.
- R3: Within a gate, each accepted pair is rebased: x = (event − first event) mod 2^EVT_W and y = (timestamp − first timestamp) mod 2^TS_W. The first pair therefore has x = y = 0, and counter wrap between samples is harmless.
- R4: The reported results are exact. `res_n` is the number of pairs accepted in the gate. `res_sx`, `res_sy`, `res_sxy` and `res_sxx` are the exact sums of x, y, x·y and x² over those pairs.
- R5: A pair can be accepted on every clock cycle, and back-to-back pairs are all counted, including when idle cycles come between them.
- R6: After `gate_stop`, `result_valid` is high for exactly one cycle. This happens once every pair accepted up to and including the stop cycle has been summed.
- R7: `gate_start` clears all sums, the overflow flag and any pairs still in the pipeline. A restart in the middle of a gate reports only the pairs accepted after the restart.
- R8: `res_ok` is 0 whenever fewer than 3 pairs were accepted.
- R9: `res_ovf` is sticky for the gate and forces `res_ok` to 0. It is set when more than 2^CNT_W pairs arrive, when a rebased x does not fit in CNT_W bits, or when any sum carries out of its width. The next `gate_start` clears it.
- R10: The result outputs hold their values between `result_valid` strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gate_start | input | 1 | Pulse: open (or restart) a gate and clear all sums |
| gate_stop | input | 1 | Pulse: close the gate; results follow after the pipeline drains |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Sample pair accepted when high together with `in_valid` |
| in_evt | input | EVT_W | Event number (x) |
| in_ts | input | TS_W | Timestamp (y) |
| result_valid | output | 1 | One-cycle strobe: result outputs updated |
| res_ok | output | 1 | N ≥ 3 and no overflow |
| res_ovf | output | 1 | Overflow occurred in this gate |
| res_n | output | CNT_W+1 | Sample count N |
| res_sx | output | 2·CNT_W | Σx |
| res_sy | output | TS_W+CNT_W | Σy |
| res_sxy | output | 2·CNT_W+TS_W | Σxy |
| res_sxx | output | 2·CNT_W+TS_W | Σx² |

## Verification
Some properties are checked on every cycle by assertions. These are the one-cycle width of the result strobe, the stability of the results between strobes, ready dropping after a stop, the first pair of a gate landing at zero offset, and a stage never losing a valid item without a flush. Others hold every cycle as well: the sample count advancing by one per summed pair, the stickiness of overflow, and the rules that tie `res_ok` to N ≥ 3 and to no overflow. The bench's scenarios are the only way to show that the sums are arithmetically exact. They also show that wrapped counters rebase correctly, that a restart discards earlier pairs, and that pairs offered while idle or draining leave no trace. For this the bench sweeps gate sizes from 0 to beyond the count limit on a small configuration and compares every result field against sums it computes itself.

// File: rtl/lsq_pkg.sv
`timescale 1ns/1ps
package lsq_pkg;
  typedef enum logic [1:0] {
    GATE_IDLE  = 2'd0,
    GATE_RUN   = 2'd1,
    GATE_DRAIN = 2'd2
  } gate_state_e;
endpackage

// File: rtl/lsq_rebase.sv
`timescale 1ns/1ps
// Stage 1: capture the gate origin and form offsets from it.
module lsq_rebase #(
  parameter int CNT_W = 24,
  parameter int EVT_W = 32,
  parameter int TS_W  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             take,
  input  logic [EVT_W-1:0] evt,
  input  logic [TS_W-1:0]  ts,
  output logic             v_q,
  output logic [CNT_W-1:0] dx_q,
  output logic [TS_W-1:0]  dy_q,
  output logic             xovf_q
);
  logic             have_base_q, have_base_n;
  logic [EVT_W-1:0] base_evt_q, base_evt_n;
  logic [TS_W-1:0]  base_ts_q, base_ts_n;
  logic [EVT_W-1:0] evt_off;
  logic [TS_W-1:0]  ts_off;
  logic [CNT_W-1:0] dx_d;
  logic             xovf_d;
  logic             v_n;
  logic             dat_en;

  assign evt_off = have_base_q ? (evt - base_evt_q) : '0;
  assign ts_off  = have_base_q ? (ts - base_ts_q) : '0;

  generate
    if (EVT_W > CNT_W) begin : g_wide_evt
      assign dx_d   = evt_off[CNT_W-1:0];
      assign xovf_d = |evt_off[EVT_W-1:CNT_W];
    end else begin : g_narrow_evt
      assign dx_d   = CNT_W'(evt_off);
      assign xovf_d = 1'b0;
    end
  endgenerate

  always_comb begin
    have_base_n = have_base_q;
    base_evt_n  = base_evt_q;
    base_ts_n   = base_ts_q;
    v_n         = take;
    dat_en      = take;
    if (flush) begin
      have_base_n = 1'b0;
      v_n         = 1'b0;
      dat_en      = 1'b0;
    end else if (take && !have_base_q) begin
      have_base_n = 1'b1;
      base_evt_n  = evt;
      base_ts_n   = ts;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_base_q <= 1'b0;
      base_evt_q  <= '0;
      base_ts_q   <= '0;
      v_q         <= 1'b0;
      dx_q        <= '0;
      dy_q        <= '0;
      xovf_q      <= 1'b0;
    end else begin
      have_base_q <= have_base_n;
      base_evt_q  <= base_evt_n;
      base_ts_q   <= base_ts_n;
      v_q         <= v_n;
      if (dat_en) begin
        dx_q   <= dx_d;
        dy_q   <= ts_off;
        xovf_q <= xovf_d;
      end
    end
  end

  // R3: the first pair of a gate enters the pipeline at offset zero
  a_r3_first_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !flush && !have_base_q) |=> (v_q && dx_q == '0 && dy_q == '0 && !xovf_q));
endmodule

// File: rtl/lsq_mul.sv
`timescale 1ns/1ps
// Stage 2: form the x*x and x*y products.
module lsq_mul #(
  parameter int CNT_W = 24,
  parameter int TS_W  = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    v_in,
  input  logic [CNT_W-1:0]        dx_in,
  input  logic [TS_W-1:0]         dy_in,
  input  logic                    xovf_in,
  output logic                    v_q,
  output logic [CNT_W-1:0]        dx_q,
  output logic [TS_W-1:0]         dy_q,
  output logic                    xovf_q,
  output logic [2*CNT_W-1:0]      pxx_q,
  output logic [CNT_W+TS_W-1:0]   pxy_q
);
  localparam int PXX_W = 2 * CNT_W;
  localparam int PXY_W = CNT_W + TS_W;

  logic [PXX_W-1:0] pxx_d;
  logic [PXY_W-1:0] pxy_d;
  logic             v_n;
  logic             dat_en;

  assign pxx_d = PXX_W'(dx_in) * PXX_W'(dx_in);
  assign pxy_d = PXY_W'(dx_in) * PXY_W'(dy_in);

  always_comb begin
    v_n    = v_in && !flush;
    dat_en = v_in && !flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      dx_q   <= '0;
      dy_q   <= '0;
      xovf_q <= 1'b0;
      pxx_q  <= '0;
      pxy_q  <= '0;
    end else begin
      v_q <= v_n;
      if (dat_en) begin
        dx_q   <= dx_in;
        dy_q   <= dy_in;
        xovf_q <= xovf_in;
        pxx_q  <= pxx_d;
        pxy_q  <= pxy_d;
      end
    end
  end

  // R5: an item in stage 1 always advances to stage 2 unless flushed
  a_r5_no_lost_item: assert property (@(posedge clk) disable iff (!rst_n)
    (v_in && !flush) |=> v_q);
endmodule

// File: rtl/lsq_acc.sv
`timescale 1ns/1ps
// Stage 3: wide accumulators with carry-out and count-limit detection.
module lsq_acc #(
  parameter int CNT_W = 24,
  parameter int TS_W  = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      v_in,
  input  logic [CNT_W-1:0]          dx,
  input  logic [TS_W-1:0]           dy,
  input  logic                      xovf,
  input  logic [2*CNT_W-1:0]        pxx,
  input  logic [CNT_W+TS_W-1:0]     pxy,
  output logic [CNT_W:0]            n_q,
  output logic [2*CNT_W-1:0]        sx_q,
  output logic [TS_W+CNT_W-1:0]     sy_q,
  output logic [2*CNT_W+TS_W-1:0]   sxy_q,
  output logic [2*CNT_W+TS_W-1:0]   sxx_q,
  output logic                      ovf_q
);
  localparam int N_W   = CNT_W + 1;
  localparam int SX_W  = 2 * CNT_W;
  localparam int SY_W  = TS_W + CNT_W;
  localparam int ACC_W = 2 * CNT_W + TS_W;
  localparam logic [N_W-1:0] N_MAX = {1'b1, {CNT_W{1'b0}}};

  logic [N_W-1:0]  n_n;
  logic [SX_W:0]   sx_ext;
  logic [SY_W:0]   sy_ext;
  logic [ACC_W:0]  sxy_ext;
  logic [ACC_W:0]  sxx_ext;
  logic [SX_W-1:0] sx_n;
  logic [SY_W-1:0] sy_n;
  logic [ACC_W-1:0] sxy_n, sxx_n;
  logic            ovf_n;
  logic            at_limit;

  assign at_limit = (n_q == N_MAX);
  assign sx_ext   = {1'b0, sx_q}  + (SX_W+1)'(dx);
  assign sy_ext   = {1'b0, sy_q}  + (SY_W+1)'(dy);
  assign sxy_ext  = {1'b0, sxy_q} + (ACC_W+1)'(pxy);
  assign sxx_ext  = {1'b0, sxx_q} + (ACC_W+1)'(pxx);

  always_comb begin
    n_n   = n_q;
    sx_n  = sx_q;
    sy_n  = sy_q;
    sxy_n = sxy_q;
    sxx_n = sxx_q;
    ovf_n = ovf_q;
    if (clr) begin
      n_n   = '0;
      sx_n  = '0;
      sy_n  = '0;
      sxy_n = '0;
      sxx_n = '0;
      ovf_n = 1'b0;
    end else if (v_in) begin
      n_n   = at_limit ? n_q : n_q + N_W'(1);
      sx_n  = sx_ext[SX_W-1:0];
      sy_n  = sy_ext[SY_W-1:0];
      sxy_n = sxy_ext[ACC_W-1:0];
      sxx_n = sxx_ext[ACC_W-1:0];
      ovf_n = ovf_q | at_limit | xovf | sx_ext[SX_W] | sy_ext[SY_W]
            | sxy_ext[ACC_W] | sxx_ext[ACC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q   <= '0;
      sx_q  <= '0;
      sy_q  <= '0;
      sxy_q <= '0;
      sxx_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      n_q   <= n_n;
      sx_q  <= sx_n;
      sy_q  <= sy_n;
      sxy_q <= sxy_n;
      sxx_q <= sxx_n;
      ovf_q <= ovf_n;
    end
  end

  // R4: each summed pair advances the count by one below the limit
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (v_in && !clr && n_q != N_MAX) |=> (n_q == $past(n_q) + N_W'(1)));
  // R9: overflow stays set until the next clear
  a_r9_sticky_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr) |=> ovf_q);
  // R9: a pair arriving at the count limit raises overflow
  a_r9_limit_trips: assert property (@(posedge clk) disable iff (!rst_n)
    (v_in && !clr && n_q == N_MAX) |=> ovf_q);
endmodule

// File: rtl/lsq_gate_accum.sv
`timescale 1ns/1ps
// Gate control, pipeline wiring and result latching.
module lsq_gate_accum #(
  parameter int CNT_W = 24,
  parameter int EVT_W = 32,
  parameter int TS_W  = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      gate_start,
  input  logic                      gate_stop,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [EVT_W-1:0]          in_evt,
  input  logic [TS_W-1:0]           in_ts,
  output logic                      result_valid,
  output logic                      res_ok,
  output logic                      res_ovf,
  output logic [CNT_W:0]            res_n,
  output logic [2*CNT_W-1:0]        res_sx,
  output logic [TS_W+CNT_W-1:0]     res_sy,
  output logic [2*CNT_W+TS_W-1:0]   res_sxy,
  output logic [2*CNT_W+TS_W-1:0]   res_sxx
);
  import lsq_pkg::*;

  localparam int N_W   = CNT_W + 1;
  localparam int SX_W  = 2 * CNT_W;
  localparam int SY_W  = TS_W + CNT_W;
  localparam int ACC_W = 2 * CNT_W + TS_W;
  localparam int PXX_W = 2 * CNT_W;
  localparam int PXY_W = CNT_W + TS_W;
  localparam logic [N_W-1:0] N_MIN_FIT = N_W'(3);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  gate_state_e state_q, state_n;
  logic        take, flush, latch_en;

  logic             v1, xovf1;
  logic [CNT_W-1:0] dx1;
  logic [TS_W-1:0]  dy1;
  logic             v2, xovf2;
  logic [CNT_W-1:0] dx2;
  logic [TS_W-1:0]  dy2;
  logic [PXX_W-1:0] pxx2;
  logic [PXY_W-1:0] pxy2;

  logic [N_W-1:0]   acc_n;
  logic [SX_W-1:0]  acc_sx;
  logic [SY_W-1:0]  acc_sy;
  logic [ACC_W-1:0] acc_sxy, acc_sxx;
  logic             acc_ovf;

  assign in_ready = (state_q == GATE_RUN) && !gate_start;
  assign take     = in_valid && in_ready;
  assign flush    = gate_start;
  assign latch_en = (state_q == GATE_DRAIN) && !v1 && !v2 && !gate_start;

  always_comb begin
    state_n = state_q;
    if (gate_start) begin
      state_n = GATE_RUN;
    end else begin
      case (state_q)
        GATE_RUN:   if (gate_stop) state_n = GATE_DRAIN;
        GATE_DRAIN: if (latch_en)  state_n = GATE_IDLE;
        default:    state_n = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) state_q <= GATE_IDLE;
    else             state_q <= state_n;
  end

  lsq_rebase #(.CNT_W(CNT_W), .EVT_W(EVT_W), .TS_W(TS_W)) u_rebase (
    .clk(clk), .rst_n(rst_sync_q), .flush(flush), .take(take),
    .evt(in_evt), .ts(in_ts),
    .v_q(v1), .dx_q(dx1), .dy_q(dy1), .xovf_q(xovf1)
  );

  lsq_mul #(.CNT_W(CNT_W), .TS_W(TS_W)) u_mul (
    .clk(clk), .rst_n(rst_sync_q), .flush(flush),
    .v_in(v1), .dx_in(dx1), .dy_in(dy1), .xovf_in(xovf1),
    .v_q(v2), .dx_q(dx2), .dy_q(dy2), .xovf_q(xovf2),
    .pxx_q(pxx2), .pxy_q(pxy2)
  );

  lsq_acc #(.CNT_W(CNT_W), .TS_W(TS_W)) u_acc (
    .clk(clk), .rst_n(rst_sync_q), .clr(flush),
    .v_in(v2), .dx(dx2), .dy(dy2), .xovf(xovf2), .pxx(pxx2), .pxy(pxy2),
    .n_q(acc_n), .sx_q(acc_sx), .sy_q(acc_sy),
    .sxy_q(acc_sxy), .sxx_q(acc_sxx), .ovf_q(acc_ovf)
  );

  // result latch
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      result_valid <= 1'b0;
      res_ok       <= 1'b0;
      res_ovf      <= 1'b0;
      res_n        <= '0;
      res_sx       <= '0;
      res_sy       <= '0;
      res_sxy      <= '0;
      res_sxx      <= '0;
    end else begin
      result_valid <= latch_en;
      if (latch_en) begin
        res_ok  <= (acc_n >= N_MIN_FIT) && !acc_ovf;
        res_ovf <= acc_ovf;
        res_n   <= acc_n;
        res_sx  <= acc_sx;
        res_sy  <= acc_sy;
        res_sxy <= acc_sxy;
        res_sxx <= acc_sxx;
      end
    end
  end

  // R6: the result strobe lasts a single cycle
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_sync_q)
    result_valid |=> !result_valid);
  // R10: results hold between strobes
  a_r10_hold_results: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !result_valid |-> ($stable(res_n) && $stable(res_sx) && $stable(res_sy)
                       && $stable(res_sxy) && $stable(res_sxx) && $stable(res_ok)));
  // R2: a stop in an open gate closes the input on the next cycle
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (gate_stop && !gate_start && in_ready) |=> !in_ready);
  // R8: a valid fit needs at least three pairs
  a_r8_min_pairs: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (result_valid && res_ok) |-> (res_n >= N_MIN_FIT));
  // R9: overflow and a valid result exclude each other
  a_r9_ok_excludes_ovf: assert property (@(posedge clk) disable iff (!rst_sync_q)
    res_ok |-> !res_ovf);
endmodule

// File: tb/tb_lsq_gate_accum.sv
`timescale 1ns/1ps
module tb_lsq_gate_accum;
  localparam int CW = 4;
  localparam int XW = 8;
  localparam int TW = 8;
  localparam int NW = CW + 1;
  localparam int SXW = 2 * CW;
  localparam int SYW = TW + CW;
  localparam int AW = 2 * CW + TW;
  localparam longint XMASK = (64'd1 << XW) - 1;
  localparam longint TMASK = (64'd1 << TW) - 1;
  localparam longint NLIM  = 64'd1 << CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_start = 1'b0, gate_stop = 1'b0, in_valid = 1'b0;
  logic [XW-1:0] in_evt = '0;
  logic [TW-1:0] in_ts = '0;
  logic in_ready, result_valid, res_ok, res_ovf;
  logic [NW-1:0] res_n;
  logic [SXW-1:0] res_sx;
  logic [SYW-1:0] res_sy;
  logic [AW-1:0] res_sxy, res_sxx;

  always #10 clk = ~clk;

  lsq_gate_accum #(.CNT_W(CW), .EVT_W(XW), .TS_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .gate_start(gate_start), .gate_stop(gate_stop),
    .in_valid(in_valid), .in_ready(in_ready), .in_evt(in_evt), .in_ts(in_ts),
    .result_valid(result_valid), .res_ok(res_ok), .res_ovf(res_ovf),
    .res_n(res_n), .res_sx(res_sx), .res_sy(res_sy),
    .res_sxy(res_sxy), .res_sxx(res_sxx)
  );

  int n_checks = 0;
  int n_fail = 0;

  // reference model
  bit     m_have;
  longint m_e0, m_t0, m_n, m_sx, m_sy, m_sxy, m_sxx;
  bit     m_ovf;

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic m_clear();
    m_have = 0; m_e0 = 0; m_t0 = 0; m_n = 0;
    m_sx = 0; m_sy = 0; m_sxy = 0; m_sxx = 0; m_ovf = 0;
  endtask

  task automatic m_take(input longint e, input longint t);
    longint dx, dy;
    if (!m_have) begin m_have = 1; m_e0 = e; m_t0 = t; end
    dx = (e - m_e0) & XMASK;
    dy = (t - m_t0) & TMASK;
    if (dx >= NLIM) m_ovf = 1;
    dx = dx & (NLIM - 1);
    if (m_n == NLIM) m_ovf = 1; else m_n++;
    m_sx += dx; m_sy += dy; m_sxy += dx * dy; m_sxx += dx * dx;
    if (m_sx >= (64'd1 << SXW) || m_sy >= (64'd1 << SYW) ||
        m_sxy >= (64'd1 << AW) || m_sxx >= (64'd1 << AW)) m_ovf = 1;
  endtask

  task automatic start_gate();
    @(negedge clk); gate_start = 1'b1; m_clear();
    @(negedge clk); gate_start = 1'b0;
  endtask

  task automatic send_seq(input int cnt, input longint e0, input longint estep,
                          input longint t0, input longint tstep, input int gap,
                          input bit stop_last);
    for (int i = 0; i < cnt; i++) begin
      longint e, t;
      if (gap > 0 && (i % gap) == gap - 1) begin
        @(negedge clk); in_valid = 1'b0;
      end
      e = (e0 + i * estep) & XMASK;
      t = (t0 + i * tstep + ((i * 3) % 4)) & TMASK;
      @(negedge clk);
      in_valid = 1'b1; in_evt = XW'(e); in_ts = TW'(t);
      gate_stop = stop_last && (i == cnt - 1);
      #1;
      if (in_ready) m_take(e, t);
    end
    @(negedge clk); in_valid = 1'b0; gate_stop = 1'b0;
  endtask

  task automatic wait_and_check(input string tag);
    bit seen = 0;
    for (int k = 0; k < 20 && !seen; k++) begin
      if (result_valid) seen = 1; else @(negedge clk);
    end
    check({tag, " R6 strobe seen"}, seen, 1);
    if (m_ovf) begin
      check({tag, " R9 ovf"}, res_ovf, 1);
      check({tag, " R9 ok low"}, res_ok, 0);
    end else begin
      check({tag, " R9 no ovf"}, res_ovf, 0);
      check({tag, " R4 n"}, res_n, m_n);
      check({tag, " R4 sx"}, res_sx, m_sx);
      check({tag, " R4 sy"}, res_sy, m_sy);
      check({tag, " R4 sxy"}, res_sxy, m_sxy);
      check({tag, " R4 sxx"}, res_sxx, m_sxx);
      check({tag, " R8 ok"}, res_ok, (m_n >= 3) ? 1 : 0);
    end
    @(negedge clk);
    check({tag, " R6 one cycle"}, result_valid, 0);
  endtask

  task automatic run_gate(input string tag, input int cnt, input longint e0,
                          input longint estep, input longint t0, input longint tstep,
                          input int gap);
    start_gate();
    if (cnt > 0) begin
      send_seq(cnt, e0, estep, t0, tstep, gap, 1'b1);
    end else begin
      @(negedge clk); gate_stop = 1'b1;
      @(negedge clk); gate_stop = 1'b0;
      check({tag, " R2 ready low draining"}, in_ready, 0);
    end
    wait_and_check(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    m_clear();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 result_valid", result_valid, 0);
    check("R1 in_ready", in_ready, 0);
    check("R1 res_ok", res_ok, 0);
    check("R1 res_ovf", res_ovf, 0);
    check("R1 res_n", res_n, 0);
    check("R1 res_sxy", res_sxy, 0);

    // R2: pairs offered while idle are refused
    @(negedge clk); in_valid = 1'b1; in_evt = 8'd5; in_ts = 8'd9;
    #1 check("R2 ready low idle", in_ready, 0);
    @(negedge clk); in_valid = 1'b0;

    // R4 R5 R8: sweep of gate sizes, back-to-back
    for (int k = 0; k <= 16; k++) begin
      run_gate("R5 sweep", k, k * 13, 1, k * 29, 10 + (k % 5), 0);
    end
    // R5: gaps between samples, stride 2
    run_gate("R5 gaps", 8, 40, 2, 7, 17, 3);
    // R3: both counters wrap inside the gate
    run_gate("R3 wrap", 10, 250, 1, 240, 3, 0);
    run_gate("R3 wrap gaps", 7, 253, 2, 200, 11, 2);

    // R9: count above limit, then x offset too wide, then clean gate
    run_gate("R9 count", 17, 3, 0, 0, 1, 0);
    run_gate("R9 xrange", 3, 0, 8, 0, 1, 0);
    run_gate("R9 cleared", 5, 1, 1, 2, 4, 0);

    // R7: restart mid-gate drops earlier pairs
    start_gate();
    send_seq(5, 100, 1, 50, 9, 0, 1'b0);
    start_gate();
    send_seq(4, 60, 3, 10, 20, 0, 1'b1);
    wait_and_check("R7 restart");
    check("R7 restart n", res_n, 4);

    // R10: results hold while idle, also with idle pairs offered
    begin
      logic [NW-1:0] hold_n;
      logic [AW-1:0] hold_sxy;
      hold_n = res_n; hold_sxy = res_sxy;
      @(negedge clk); in_valid = 1'b1; in_evt = 8'd77; in_ts = 8'd88;
      repeat (5) @(negedge clk);
      in_valid = 1'b0;
      check("R10 hold n", res_n, hold_n);
      check("R10 hold sxy", res_sxy, hold_sxy);
      check("R10 no strobe", result_valid, 0);
    end
    report();
  end
endmodule